// File: doc/BRIEF.md
# Lookahead Thread Issue Gate

This block sits in front of a long, non-bypassed instruction pipeline shared by many hardware threads. Every cycle it chooses at most one thread that has an instruction ready and grants it a launch slot. Each instruction carries a 3-bit lookahead value, 0 to 7. The value states how many of the same thread's following instructions do not depend on it. The gate uses these values in place of a register scoreboard: a thread runs ahead on credit while the lookahead allows, then stalls until the instruction that set the credit has left the pipeline.

An instruction that issues while its thread has zero credit is called an anchor. Its lookahead loads the thread's credit, and the gate notes that the anchor is in flight. Each later issue from that thread uses up one credit. The lookahead carried by a credited instruction is not used. When the credit reaches zero, the thread may not issue again until its anchor leaves the pipeline, which happens a fixed number of cycles after it issued. Threads that are eligible are served round-robin, and the search starts at the thread after the one that issued last.

Each thread offers its instruction with a valid flag (`thr_avail`) and its lookahead. The gate returns a one-hot ready (`thr_take`) in the same cycle, and the instruction is launched in any cycle where both are high. A thread that is not taken holds its instruction and keeps its valid high. A thread may lower valid at any time, which costs it only its slot. The pipeline below never stalls, so the issue output has no ready input.

Top module: `la_issue_gate`

## Requirements
- R1: While reset is asserted, no thread is taken. After reset every thread has zero credit and no anchor in flight, and the first search starts at thread 0.
- R2: At most one `thr_take` bit is high in a cycle. `issue_valid` is high exactly when one is high. `issue_tid` is that thread's index, and `issue_la` is the lookahead it offers in that cycle.
- R3: If any thread is eligible in a cycle, an instruction is issued in that cycle.
- R4: The eligible thread chosen is the first one found when searching upward, with wrap-around, from the thread after the last issued thread.
- R5: An anchor (issued at zero credit) loads the thread's credit with its 3-bit lookahead L. The thread can then issue L more instructions in consecutive cycles.
- R6: The lookahead of an instruction issued with nonzero credit is ignored. That issue only lowers the credit by one.
- R7: A thread with zero credit whose anchor is in flight is not eligible. An anchor issued in cycle c stops blocking from cycle c+PIPE_DEPTH. A lone thread with lookahead 0 therefore issues once every PIPE_DEPTH (21) cycles.
- R8: A thread whose `thr_avail` is low is never taken, and its credit and in-flight state do not change.
- R9: Credit left over when a thread lowers valid, or when its anchor departs, is kept and spent when the thread returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_avail | input | NUM_THREADS | Per-thread instruction valid |
| thr_la | input | NUM_THREADS*3 | Per-thread lookahead, thread t at bits [3t+2:3t] |
| thr_take | output | NUM_THREADS | One-hot ready: the thread's instruction is launched this cycle |
| issue_valid | output | 1 | An instruction is launched this cycle |
| issue_tid | output | $clog2(NUM_THREADS) | Index of the launching thread |
| issue_la | output | 3 | Lookahead of the launched instruction |

## Verification
The bench builds the gate with 8 threads and a 21-cycle pipeline. With this size, every lookahead value can be swept on its own thread inside two pipeline lengths. The wrap-around of the round-robin search is reached many times in a short run. A per-cycle arithmetic model of credit, anchor expiry and search order checks every cycle. The model is fed directed phases for credit carry-over and for ignored lookahead, followed by a long pseudo-random mix of valid and lookahead patterns.

// File: rtl/lagate_pkg.sv
package lagate_pkg;
  // Lookahead width is fixed by the instruction format: 0..7 independent successors.
  localparam int LA_W = 3;
  typedef logic [LA_W-1:0] la_t;
endpackage

// File: rtl/lagate_thread_ctx.sv
module lagate_thread_ctx
  import lagate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic avail,
  input  logic take,
  input  la_t  la_in,
  input  logic ret,
  output logic elig,
  output logic anchor
);
  la_t  credit_q;
  logic inflight_q;

  // An issue at zero credit opens a new anchor.
  assign anchor = (credit_q == '0);
  assign elig   = avail && !(anchor && inflight_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_q   <= '0;
      inflight_q <= 1'b0;
    end else begin
      if (take) credit_q <= anchor ? la_in : credit_q - 1'b1;
      if (take && anchor)  inflight_q <= 1'b1;
      else if (ret)        inflight_q <= 1'b0;
    end
  end

  // R8
  take_needs_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> avail);
  // R7
  zero_la_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && anchor && la_in == '0) |=> !take);
  // R7
  retire_matches_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret |-> inflight_q);
endmodule

// File: rtl/lagate_retire_pipe.sv
module lagate_retire_pipe #(
  parameter int NUM_THREADS = 8,
  parameter int PIPE_DEPTH  = 21,
  localparam int TID_W  = $clog2(NUM_THREADS),
  localparam int STAGES = PIPE_DEPTH - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [TID_W-1:0]       push_tid,
  output logic [NUM_THREADS-1:0] ret_vec
);
  // The issue cycle itself counts as the first pipeline cycle, so STAGES
  // registers make the departure visible PIPE_DEPTH-1 cycles after issue.
  logic             vld_q [STAGES];
  logic [TID_W-1:0] tid_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        vld_q[s] <= 1'b0;
        tid_q[s] <= '0;
      end
    end else begin
      vld_q[0] <= push;
      tid_q[0] <= push_tid;
      for (int s = 1; s < STAGES; s++) begin
        vld_q[s] <= vld_q[s-1];
        tid_q[s] <= tid_q[s-1];
      end
    end
  end

  always_comb begin
    ret_vec = '0;
    if (vld_q[STAGES-1]) ret_vec[tid_q[STAGES-1]] = 1'b1;
  end
endmodule

// File: rtl/lagate_rr_pick.sv
module lagate_rr_pick #(
  parameter int NUM_THREADS = 8,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] req,
  output logic [NUM_THREADS-1:0] gnt,
  output logic [TID_W-1:0]       gnt_idx,
  output logic                   any
);
  logic [TID_W-1:0] last_q;
  int unsigned idx;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    idx     = 0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      idx = (int'(last_q) + k) % NUM_THREADS;
      if (!any && req[idx]) begin
        any          = 1'b1;
        gnt[idx]     = 1'b1;
        gnt_idx      = TID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= TID_W'(NUM_THREADS - 1);
    else if (any) last_q <= gnt_idx;
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R3
  work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/la_issue_gate.sv
module la_issue_gate
  import lagate_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int PIPE_DEPTH  = 21,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_THREADS-1:0]      thr_avail,
  input  logic [NUM_THREADS*LA_W-1:0] thr_la,
  output logic [NUM_THREADS-1:0]      thr_take,
  output logic                        issue_valid,
  output logic [TID_W-1:0]            issue_tid,
  output logic [LA_W-1:0]             issue_la
);
  logic [NUM_THREADS-1:0] elig, anchor, ret_vec, req, gnt;
  logic [TID_W-1:0]       gnt_idx;
  logic                   any;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    lagate_thread_ctx u_ctx (
      .clk    (clk),
      .rst_n  (rst_n),
      .avail  (thr_avail[t]),
      .take   (gnt[t]),
      .la_in  (thr_la[t*LA_W +: LA_W]),
      .ret    (ret_vec[t]),
      .elig   (elig[t]),
      .anchor (anchor[t])
    );
  end

  // No thread is offered a slot while reset is held.
  assign req = elig & {NUM_THREADS{rst_n}};

  lagate_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any)
  );

  lagate_retire_pipe #(.NUM_THREADS(NUM_THREADS), .PIPE_DEPTH(PIPE_DEPTH)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (any && anchor[gnt_idx]),
    .push_tid (gnt_idx),
    .ret_vec  (ret_vec)
  );

  assign thr_take    = gnt;
  assign issue_valid = any;
  assign issue_tid   = gnt_idx;
  assign issue_la    = any ? thr_la[gnt_idx*LA_W +: LA_W] : '0;

  // R2
  issue_matches_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (thr_take[issue_tid] && thr_avail[issue_tid]));
endmodule

// File: tb/la_issue_gate_tb.sv
module la_issue_gate_tb;
  localparam int N = 8;
  localparam int D = 21;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   avail = '0;
  logic [2:0]     la_v [N];
  logic [N*3-1:0] la_bus;
  logic [N-1:0]   take;
  logic           issue_valid;
  logic [2:0]     issue_tid;
  logic [2:0]     issue_la;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int t = 0; t < N; t++) la_bus[t*3 +: 3] = la_v[t];

  la_issue_gate #(.NUM_THREADS(N), .PIPE_DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_avail(avail), .thr_la(la_bus),
    .thr_take(take), .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_la(issue_la)
  );

  int checks = 0, fails = 0;
  int m_credit [N];
  int m_until  [N];
  int m_last;
  int cyc;
  int cnt [N];
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clr_cnt();
    for (int t = 0; t < N; t++) cnt[t] = 0;
  endtask

  // Inputs are already set; check this cycle's outputs, then advance.
  task automatic step();
    int e;
    #1;
    e = -1;
    for (int k = 1; k <= N; k++) begin
      int t;
      t = (m_last + k) % N;
      if (e < 0 && avail[t] && !(m_credit[t] == 0 && cyc < m_until[t])) e = t;
    end
    chk(issue_valid == (e >= 0), "R3 issue_valid", int'(issue_valid), int'(e >= 0));
    if (e >= 0) begin
      chk(int'(issue_tid) == e, "R4 issue_tid", int'(issue_tid), e);
      chk(issue_la == la_v[e], "R2 issue_la", int'(issue_la), int'(la_v[e]));
      chk(take == N'(1 << e), "R2 thr_take", int'(take), 1 << e);
      if (m_credit[e] == 0) begin
        m_credit[e] = int'(la_v[e]);
        m_until[e]  = cyc + D;
      end else begin
        m_credit[e] = m_credit[e] - 1;
      end
      m_last = e;
    end else begin
      chk(take == '0, "R2 thr_take idle", int'(take), 0);
    end
    chk((take & ~avail) == '0, "R8 take without avail", int'(take & ~avail), 0);
    if (issue_valid) cnt[issue_tid]++;
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < N; t++) begin
      la_v[t] = 3'd0; m_credit[t] = 0; m_until[t] = 0;
    end
    m_last = N - 1;
    cyc = 0;
    clr_cnt();
    // R1: held reset with every thread offering
    avail = '1;
    repeat (3) @(negedge clk);
    #1;
    chk(issue_valid == 1'b0, "R1 valid in reset", int'(issue_valid), 0);
    chk(take == '0, "R1 take in reset", int'(take), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk(cnt[0] == 1, "R1 first grant thread 0", cnt[0], 1);
    avail = '0;
    run(25);

    // R5/R7 sweep: thread t alone with lookahead t over two pipeline lengths
    for (int t = 0; t < N; t++) begin
      clr_cnt();
      la_v[t] = 3'(t);
      avail = N'(1 << t);
      run(2 * D);
      chk(cnt[t] == 2 * (t + 1), "R5/R7 issues per two windows", cnt[t], 2 * (t + 1));
      avail = '0;
    end
    run(D + 4);

    // R6: anchor lookahead 2, later instructions claim 7
    clr_cnt();
    la_v[2] = 3'd2;
    avail = N'(1 << 2);
    step();
    la_v[2] = 3'd7;
    run(D - 1);
    chk(cnt[2] == 3, "R6 credited lookahead ignored", cnt[2], 3);
    avail = '0;
    run(D + 4);

    // R9: credit survives valid drop and anchor departure
    la_v[1] = 3'd5;
    avail = N'(1 << 1);
    run(2);
    avail = '0;
    run(30);
    clr_cnt();
    la_v[1] = 3'd0;
    avail = N'(1 << 1);
    run(D);
    chk(cnt[1] == 5, "R9 kept credit then anchor", cnt[1], 5);
    avail = '0;
    run(D + 4);

    // R8: thread 6 held off while the others run
    clr_cnt();
    for (int t = 0; t < N; t++) la_v[t] = 3'd7;
    avail = 8'hBF;
    run(60);
    chk(cnt[6] == 0, "R8 idle thread untouched", cnt[6], 0);
    chk(cnt[5] > 0, "R4 others served", cnt[5], 1);
    avail = '0;
    run(D + 4);
    clr_cnt();
    la_v[6] = 3'd0;
    avail = N'(1 << 6);
    step();
    chk(cnt[6] == 1, "R8 state fresh after hold-off", cnt[6], 1);
    avail = '0;
    run(D + 4);

    // R3/R4 mixed pseudo-random load
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      avail = lfsr[7:0] | lfsr[15:8];
      for (int t = 0; t < N; t++) la_v[t] = 3'((lfsr >> t) ^ 16'(i));
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule